// File: doc/BRIEF.md
# Flash Instruction Sequence Engine

This block runs one command sequence for a serial flash controller. Software fills a writable table with compact 16-bit instructions, two per 32-bit word and eight per sequence. A trigger names a sequence. The engine first scans that sequence for illegal content with chip select high. It then walks the instructions again with chip select low and hands one phase record per instruction to a downstream serializer. Each record holds the phase kind, the number of data lines, the SDR/DDR flag and a bit or cycle count.

A sequence ends at a stop instruction, at a jump instruction, or after its eighth instruction. A jump instruction also saves its operand as an instruction pointer. Later starts that are not issued from the host register path begin at that pointer. Illegal content or an overlong run ends the sequence with an error code and the index of the sequence that failed. Pin shifting, sampling and clock generation belong to the serializer.

Top module: `flash_seq_engine`

## Requirements
- R1: Table word w holds instruction slot 2w in bits [15:0] and slot 2w+1 in bits [31:16]. Sequence s starts at word 4s. Inside an instruction, bits [15:10] are the opcode, bits [9:8] the pad code and bits [7:0] the operand.
- R2: Each executed non-ending instruction gives one record with the following fields:
  - ph_kind is opcode[4:0] and ph_ddr is opcode[5].
  - ph_pads is the pad code: 0, 1, 2 or 3 for one, two, four or eight lines.
  - ph_bits is 8 for a command (kind 0x01) and 1, 2, 4 or 8 for mode kinds 0x04 to 0x07.
  - For every other kind, ph_bits is the operand.
- R3: While ph_valid is high and ph_ready is low, the record stays unchanged. A record is consumed only on a cycle with both high, and records leave in slot order.
- R4: Opcode 0x00 ends the sequence. No record is emitted for it, cs_n returns high and done pulses for one cycle. ph_valid is only ever high while cs_n is low.
- R5: A sequence without an ending instruction ends, with done, once its eighth record is accepted.
- R6: Opcode 0x1F ends the sequence like 0x00 and saves its operand as an instruction pointer, taken modulo 128. A later start with start_host low begins at that pointer. A start with start_host high always begins at slot 0 of start_seq.
- R7: Opcode 0x1F in a sequence started with start_host high gives error code 0x2. No record is emitted and cs_n stays high.
- R8: Known opcodes are 0x00, 0x1F, 0x01–0x0D and 0x21–0x2D. Any other opcode in the scanned part of a sequence gives error code 0x3 with no record.
- R9: The first command or address instruction (kinds 0x01–0x03) sets the sequence mode. A dummy (kind 0x0C or 0x0D) whose DDR bit disagrees with that mode is an error, wherever the dummy sits in the scanned part:
  - code 0x4 for an SDR dummy in a DDR sequence;
  - code 0x5 for a DDR dummy in an SDR sequence.
- R10: A sequence still running tmo_limit×1024 cycles after its start aborts with code 0xE and cs_n high. A tmo_limit of 0 disables the limit.
- R11: On every error, err pulses for one cycle and err_seq holds the index of the sequence where the run started.
- R12: After reset, cs_n is high, busy is low, ph_valid is low and no pointer is saved.
- R13: A start that arrives while busy is high has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 6 | Table word address |
| lut_wdata | input | 32 | Table word data |
| tmo_limit | input | 8 | Timeout in units of 1024 cycles, 0 disables |
| start | input | 1 | Start a sequence (ignored while busy) |
| start_seq | input | 4 | Sequence index to start |
| start_host | input | 1 | Start comes from the host register path |
| ph_ready | input | 1 | Serializer accepts the current record |
| busy | output | 1 | A sequence is being scanned or executed |
| cs_n | output | 1 | Chip select, active low |
| ph_valid | output | 1 | Record valid |
| ph_kind | output | 5 | Phase kind (opcode without DDR bit) |
| ph_pads | output | 2 | Pad code |
| ph_ddr | output | 1 | Phase uses DDR |
| ph_bits | output | 8 | Bit or cycle count |
| done | output | 1 | One-cycle pulse, sequence finished |
| err | output | 1 | One-cycle pulse, sequence failed |
| err_code | output | 4 | Error code of the last failure |
| err_seq | output | 4 | Sequence index of the last failure |

## Verification
The assertions check several rules on every cycle:
- a stalled record holds still;
- records appear only with chip select low, and chip select stays high while idle and during the scan;
- done and err never coincide, and every error code is legal;
- a start during a run leaves the start pointer alone;
- the timeout counter never passes its span, and a timeout always ends the run.

Only the bench scenarios show the rest. These are the decoded record values, the sweep over all 64 opcodes, the pending-dummy mismatch that resolves at a later address instruction, and the saved jump pointer steering a later start. They also cover the 1024-cycle timeout arithmetic and the disabled timeout that waits indefinitely.

// File: rtl/flash_seq_pkg.sv
// Shared types and decode helpers for the flash instruction sequence engine.
// Assumes the 16-bit instruction layout {opcode[5:0], pads[1:0], operand[7:0]}.
package flash_seq_pkg;

    typedef struct packed {
        logic [5:0] opcode;
        logic [1:0] pads;
        logic [7:0] operand;
    } instr_t;

    typedef enum logic [3:0] {
        ERR_NONE      = 4'h0,
        ERR_JUMP_HOST = 4'h2,
        ERR_BAD_OP    = 4'h3,
        ERR_SDR_DUMMY = 4'h4,
        ERR_DDR_DUMMY = 4'h5,
        ERR_TIMEOUT   = 4'hE
    } err_code_e;

    localparam logic [5:0] OP_STOP = 6'h00;
    localparam logic [5:0] OP_JUMP = 6'h1F;
    localparam logic [4:0] K_CMD   = 5'h01;
    localparam logic [4:0] K_CADDR = 5'h03;
    localparam logic [4:0] K_MODE1 = 5'h04;
    localparam logic [4:0] K_MODE8 = 5'h07;
    localparam logic [4:0] K_DUMMY = 5'h0C;
    localparam logic [4:0] K_DSTRB = 5'h0D;

    // True for every opcode the engine can execute.
    function automatic logic op_known(input logic [5:0] op);
        return (op == OP_STOP) || (op == OP_JUMP) ||
               (!op[4] && (op[3:0] != 4'h0) && (op[3:0] <= 4'hD));
    endfunction

    // True for the two opcodes that terminate a sequence.
    function automatic logic op_is_end(input logic [5:0] op);
        return (op == OP_STOP) || (op == OP_JUMP);
    endfunction

    // True for either dummy kind, SDR or DDR.
    function automatic logic op_is_dummy(input logic [5:0] op);
        return op_known(op) && ((op[4:0] == K_DUMMY) || (op[4:0] == K_DSTRB));
    endfunction

    // True for command and address kinds, which fix the sequence mode.
    function automatic logic op_is_ref(input logic [5:0] op);
        return op_known(op) && !op_is_end(op) && (op[4:0] >= K_CMD) && (op[4:0] <= K_CADDR);
    endfunction

    // Bit or cycle count carried by a phase record.
    function automatic logic [7:0] phase_bits(input instr_t ins);
        logic [4:0] kind;
        kind = ins.opcode[4:0];
        if (kind == K_CMD) return 8'd8;
        if ((kind >= K_MODE1) && (kind <= K_MODE8)) return 8'd1 << kind[1:0];
        return ins.operand;
    endfunction

endpackage

// File: rtl/seq_lut.sv
// Instruction table: one synchronous write port and one combinational read port.
// Assumes software loads a word before any sequence reads it (contents are not reset).
module seq_lut #(
    parameter int WORDS = 64,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);

    logic [31:0] mem [WORDS];

    // Store one table word per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the addressed word to the sequencer in the same cycle.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/seq_timeout.sv
// Run-length watchdog: raises hit once a run has lasted limit * 2**UNIT_SHIFT cycles.
// Assumes limit is held stable while run is high; limit 0 disables the check.
module seq_timeout #(
    parameter int LIM_W      = 8,
    parameter int UNIT_SHIFT = 10,
    localparam int CW = LIM_W + UNIT_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LIM_W-1:0] limit,
    output logic             hit
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] span;

    assign span = {limit, {UNIT_SHIFT{1'b0}}};
    assign hit  = run && (limit != '0) && (cnt == span - CW'(1));

    // Count cycles of the current run, restarting whenever the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (!run) cnt <= '0;
        else           cnt <= cnt + CW'(1);
    end

    // R10: the count never walks past the configured span.
    p_tmo_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0) |-> (cnt < span));

    // R10: a timeout always ends the run in the following cycle.
    p_hit_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !run);

endmodule

// File: rtl/seq_rule_check.sv
// Per-instruction legality check used while a sequence is scanned.
// Assumes ref_* and pend_* summarise the earlier instructions of the same scan.
module seq_rule_check
    import flash_seq_pkg::*;
(
    input  logic       [5:0] opcode,
    input  logic             from_host,
    input  logic             ref_valid,
    input  logic             ref_ddr,
    input  logic             pend_sdr,
    input  logic             pend_ddr,
    output logic             viol,
    output err_code_e        code
);

    // Pick the first applicable rule for this instruction.
    always_comb begin
        viol = 1'b0;
        code = ERR_NONE;
        if (!op_known(opcode)) begin
            viol = 1'b1;
            code = ERR_BAD_OP;
        end else if ((opcode == OP_JUMP) && from_host) begin
            viol = 1'b1;
            code = ERR_JUMP_HOST;
        end else if (op_is_dummy(opcode) && ref_valid && (opcode[5] != ref_ddr)) begin
            viol = 1'b1;
            code = opcode[5] ? ERR_DDR_DUMMY : ERR_SDR_DUMMY;
        end else if (op_is_ref(opcode) && !ref_valid && (opcode[5] ? pend_sdr : pend_ddr)) begin
            viol = 1'b1;
            code = opcode[5] ? ERR_SDR_DUMMY : ERR_DDR_DUMMY;
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
// Sequencer: scans a sequence for illegal content with chip select high, then
// executes it with chip select low, emitting one record per instruction.
// Assumes SEQS and SLOTS are powers of two and the table read is combinational.
module seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int SEQS  = 16,
    parameter int SLOTS = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int TOTAL  = SEQS * SLOTS,
    localparam int IPTR_W = $clog2(TOTAL),
    localparam int SW     = $clog2(SEQS),
    localparam int AW     = IPTR_W - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] start_seq,
    input  logic          from_host,
    output logic [AW-1:0] rd_addr,
    input  logic [31:0]   rd_data,
    input  logic          tmo_hit,
    input  logic          ph_ready,
    output logic          busy,
    output logic          cs_n,
    output logic          ph_valid,
    output logic [4:0]    ph_kind,
    output logic [1:0]    ph_pads,
    output logic          ph_ddr,
    output logic [7:0]    ph_bits,
    output logic          done,
    output logic          err,
    output logic [3:0]    err_code,
    output logic [SW-1:0] err_seq
);

    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_EXEC} state_e;

    state_e            state;
    logic [IPTR_W-1:0] base, ptr, start_ptr;
    logic [SLOT_W-1:0] cnt;
    logic              host_q, ref_valid, ref_ddr, pend_sdr, pend_ddr;
    logic              jptr_v, cs_n_q, done_q, err_q;
    logic [7:0]        jptr;
    err_code_e         code_q, vcode;
    logic [SW-1:0]     eseq_q;
    instr_t            cur;
    logic              viol, cur_end, last_slot;

    // Fetch: current instruction is slot cnt counted from the start pointer.
    assign ptr       = base + IPTR_W'(cnt);
    assign rd_addr   = ptr[IPTR_W-1:1];
    assign cur       = ptr[0] ? instr_t'(rd_data[31:16]) : instr_t'(rd_data[15:0]);
    assign cur_end   = op_is_end(cur.opcode);
    assign last_slot = (cnt == SLOT_W'(SLOTS - 1));
    assign start_ptr = (from_host || !jptr_v) ? {start_seq, {SLOT_W{1'b0}}}
                                              : IPTR_W'({24'd0, jptr} % TOTAL);

    seq_rule_check u_rule (
        .opcode    (cur.opcode),
        .from_host (host_q),
        .ref_valid (ref_valid),
        .ref_ddr   (ref_ddr),
        .pend_sdr  (pend_sdr),
        .pend_ddr  (pend_ddr),
        .viol      (viol),
        .code      (vcode)
    );

    // Record and flag outputs.
    assign busy     = (state != S_IDLE);
    assign cs_n     = cs_n_q;
    assign ph_valid = (state == S_EXEC) && !cur_end && !tmo_hit;
    assign ph_kind  = cur.opcode[4:0];
    assign ph_pads  = cur.pads;
    assign ph_ddr   = cur.opcode[5];
    assign ph_bits  = phase_bits(cur);
    assign done     = done_q;
    assign err      = err_q;
    assign err_code = code_q;
    assign err_seq  = eseq_q;

    // Sequencer state machine: idle, scan for legality, execute with CS low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            base      <= '0;
            cnt       <= '0;
            host_q    <= 1'b0;
            ref_valid <= 1'b0;
            ref_ddr   <= 1'b0;
            pend_sdr  <= 1'b0;
            pend_ddr  <= 1'b0;
            jptr_v    <= 1'b0;
            jptr      <= '0;
            cs_n_q    <= 1'b1;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            code_q    <= ERR_NONE;
            eseq_q    <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        base      <= start_ptr;
                        cnt       <= '0;
                        host_q    <= from_host;
                        ref_valid <= 1'b0;
                        ref_ddr   <= 1'b0;
                        pend_sdr  <= 1'b0;
                        pend_ddr  <= 1'b0;
                        state     <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (tmo_hit || viol) begin
                        state  <= S_IDLE;
                        err_q  <= 1'b1;
                        code_q <= tmo_hit ? ERR_TIMEOUT : vcode;
                        eseq_q <= base[IPTR_W-1:SLOT_W];
                    end else begin
                        if (op_is_ref(cur.opcode) && !ref_valid) begin
                            ref_valid <= 1'b1;
                            ref_ddr   <= cur.opcode[5];
                        end
                        if (op_is_dummy(cur.opcode) && !ref_valid) begin
                            if (cur.opcode[5]) pend_ddr <= 1'b1;
                            else               pend_sdr <= 1'b1;
                        end
                        if (cur_end || last_slot) begin
                            state  <= S_EXEC;
                            cnt    <= '0;
                            cs_n_q <= 1'b0;
                        end else begin
                            cnt <= cnt + SLOT_W'(1);
                        end
                    end
                end
                S_EXEC: begin
                    if (tmo_hit) begin
                        state  <= S_IDLE;
                        cs_n_q <= 1'b1;
                        err_q  <= 1'b1;
                        code_q <= ERR_TIMEOUT;
                        eseq_q <= base[IPTR_W-1:SLOT_W];
                    end else if (cur_end) begin
                        state  <= S_IDLE;
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                        if (cur.opcode == OP_JUMP) begin
                            jptr   <= cur.operand;
                            jptr_v <= 1'b1;
                        end
                    end else if (ph_ready) begin
                        if (last_slot) begin
                            state  <= S_IDLE;
                            cs_n_q <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            cnt <= cnt + SLOT_W'(1);
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R3: a stalled record holds still unless the run is aborted.
    p_hold_rec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_valid && !ph_ready) |=> (tmo_hit || (ph_valid && $stable({ph_kind, ph_pads, ph_ddr, ph_bits}))));

    // R4: records only appear with chip select asserted.
    p_rec_cs_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ph_valid |-> !cs_n);

    // R4: completion and failure never share a cycle.
    p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R7: chip select is never driven during the legality scan.
    p_scan_cs_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN) |-> cs_n);

    // R8: reported codes come from the defined set.
    p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code inside {4'h2, 4'h3, 4'h4, 4'h5, 4'hE}));

    // R12: chip select is high whenever the engine is idle.
    p_idle_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R13: a start during a run does not move the start pointer.
    p_busy_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(base));

endmodule

// File: rtl/flash_seq_engine.sv
// Top of the flash instruction sequence engine: instruction table, run-length
// watchdog and sequencer. Assumes one clock domain shared with the serializer.
module flash_seq_engine #(
    parameter int SEQS       = 16,
    parameter int SLOTS      = 8,
    parameter int TMO_W      = 8,
    parameter int UNIT_SHIFT = 10,
    localparam int WORDS = SEQS * SLOTS / 2,
    localparam int AW    = $clog2(WORDS),
    localparam int SW    = $clog2(SEQS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lut_we,
    input  logic [AW-1:0] lut_addr,
    input  logic [31:0]   lut_wdata,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic          start,
    input  logic [SW-1:0] start_seq,
    input  logic          start_host,
    input  logic          ph_ready,
    output logic          busy,
    output logic          cs_n,
    output logic          ph_valid,
    output logic [4:0]    ph_kind,
    output logic [1:0]    ph_pads,
    output logic          ph_ddr,
    output logic [7:0]    ph_bits,
    output logic          done,
    output logic          err,
    output logic [3:0]    err_code,
    output logic [SW-1:0] err_seq
);

    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data;
    logic          tmo_hit;
    logic          busy_i;

    assign busy = busy_i;

    seq_lut #(.WORDS(WORDS)) u_lut (
        .clk     (clk),
        .wr_en   (lut_we),
        .wr_addr (lut_addr),
        .wr_data (lut_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    seq_timeout #(.LIM_W(TMO_W), .UNIT_SHIFT(UNIT_SHIFT)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_i),
        .limit (tmo_limit),
        .hit   (tmo_hit)
    );

    seq_ctrl #(.SEQS(SEQS), .SLOTS(SLOTS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_seq (start_seq),
        .from_host (start_host),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .tmo_hit   (tmo_hit),
        .ph_ready  (ph_ready),
        .busy      (busy_i),
        .cs_n      (cs_n),
        .ph_valid  (ph_valid),
        .ph_kind   (ph_kind),
        .ph_pads   (ph_pads),
        .ph_ddr    (ph_ddr),
        .ph_bits   (ph_bits),
        .done      (done),
        .err       (err),
        .err_code  (err_code),
        .err_seq   (err_seq)
    );

endmodule

// File: tb/flash_seq_engine_bench.sv
module flash_seq_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lut_we = 1'b0;
    logic [5:0]  lut_addr = '0;
    logic [31:0] lut_wdata = '0;
    logic [7:0]  tmo_limit = 8'd8;
    logic        start = 1'b0;
    logic [3:0]  start_seq = '0;
    logic        start_host = 1'b0;
    logic        ph_ready = 1'b0;
    logic        busy, cs_n, ph_valid, ph_ddr, done, err;
    logic [4:0]  ph_kind;
    logic [1:0]  ph_pads;
    logic [7:0]  ph_bits;
    logic [3:0]  err_code, err_seq;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [15:0] img [128];
    int r_kind [16];
    int r_pads [16];
    int r_ddr  [16];
    int r_bits [16];
    int nrec, cs_bad, ncyc, got_done, got_err, got_code, got_seq;

    always #10 clk = ~clk;

    flash_seq_engine u_flash_seq_engine (
        .clk(clk), .rst_n(rst_n), .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
        .tmo_limit(tmo_limit), .start(start), .start_seq(start_seq), .start_host(start_host),
        .ph_ready(ph_ready), .busy(busy), .cs_n(cs_n), .ph_valid(ph_valid), .ph_kind(ph_kind),
        .ph_pads(ph_pads), .ph_ddr(ph_ddr), .ph_bits(ph_bits), .done(done), .err(err),
        .err_code(err_code), .err_seq(err_seq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // Expected count from R2.
    function automatic int exp_bits(input int op, input int opnd);
        int k = op % 32;
        if (k == 1) return 8;
        if (k >= 4 && k <= 7) return 1 << (k - 4);
        return opnd;
    endfunction

    // Known opcode set from R8.
    function automatic bit exp_known(input int op);
        return (op == 0) || (op == 31) || (op < 64 && (op & 16) == 0 && (op & 15) >= 1 && (op & 15) <= 13);
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        lut_we = 1'b1; lut_addr = 6'(a); lut_wdata = d;
        @(negedge clk);
        lut_we = 1'b0;
    endtask

    // R1 layout: slot 2w low half, slot 2w+1 high half of word w.
    task automatic set_ins(input int s, input int slot, input int op, input int pads, input int opnd);
        int w;
        img[s*8+slot] = {6'(op), 2'(pads), 8'(opnd)};
        w = (s*8 + slot) / 2;
        wr(w, {img[2*w+1], img[2*w]});
    endtask

    // mode: 0 always ready, 1 every third cycle, 2 never, 3 after 2500 cycles.
    task automatic run(input int sq, input bit host, input int mode, input bit poke, input int maxc);
        got_done = 0; got_err = 0; got_code = 0; got_seq = 0; nrec = 0; cs_bad = 0; ncyc = 0;
        @(negedge clk);
        start_seq = 4'(sq); start_host = host; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= maxc; n++) begin
            ncyc = n;
            if (done || err) begin
                got_done = int'(done); got_err = int'(err);
                got_code = int'(err_code); got_seq = int'(err_seq);
                break;
            end
            if (poke && n == 3) begin start = 1'b1; start_seq = 4'd3; end
            else start = 1'b0;
            case (mode)
                0: ph_ready = 1'b1;
                1: ph_ready = (n % 3 == 0);
                2: ph_ready = 1'b0;
                default: ph_ready = (n > 2500);
            endcase
            if (ph_valid && cs_n) cs_bad++;
            if (ph_valid && ph_ready && nrec < 16) begin
                r_kind[nrec] = int'(ph_kind); r_pads[nrec] = int'(ph_pads);
                r_ddr[nrec] = int'(ph_ddr); r_bits[nrec] = int'(ph_bits);
                nrec++;
            end
            @(negedge clk);
        end
        ph_ready = 1'b0; start = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int mo[8], mp[8], mv[8];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "cs_n", int'(cs_n), 1);
        chk("R12", "busy", int'(busy), 0);
        chk("R12", "ph_valid", int'(ph_valid), 0);
        chk("R12", "done|err", int'(done | err), 0);

        for (int i = 0; i < 128; i++) img[i] = '0;
        for (int w = 0; w < 64; w++) wr(w, 32'd0);

        // Opcode sweep on sequence 0, slot 1 is a stop: R2, R4, R7, R8.
        for (int op = 0; op < 64; op++) begin
            int pd = op % 4;
            int od = (op * 5 + 3) % 256;
            set_ins(0, 0, op, pd, od);
            run(0, 1'b1, 0, 1'b0, 200);
            chk("R4", "cs_n after end", int'(cs_n), 1);
            chk("R4", "records with cs high", cs_bad, 0);
            if (op == 0) begin
                chk("R4", "stop done", got_done, 1);
                chk("R4", "stop records", nrec, 0);
            end else if (op == 31) begin
                chk("R7", "jump host err", got_err, 1);
                chk("R7", "jump host code", got_code, 2);
                chk("R7", "jump host records", nrec, 0);
            end else if (exp_known(op)) begin
                chk("R2", "done", got_done, 1);
                chk("R2", "records", nrec, 1);
                chk("R2", "kind", r_kind[0], op % 32);
                chk("R2", "ddr", r_ddr[0], op / 32);
                chk("R2", "pads", r_pads[0], pd);
                chk("R2", "bits", r_bits[0], exp_bits(op, od));
            end else begin
                chk("R8", "unknown err", got_err, 1);
                chk("R8", "unknown code", got_code, 3);
                chk("R8", "unknown records", nrec, 0);
            end
        end

        // Full eight-instruction SDR sequence on seq 2, stalled handshake: R1, R3, R5.
        mo = '{1, 2, 6, 12, 9, 11, 8, 10};
        mp = '{0, 2, 2, 2, 2, 0, 3, 1};
        mv = '{6, 24, 165, 6, 128, 16, 32, 1};
        for (int i = 0; i < 8; i++) set_ins(2, i, mo[i], mp[i], mv[i]);
        for (int pass = 0; pass < 2; pass++) begin
            run(2, 1'b1, 1, pass == 1, 400);
            chk("R5", "eight done", got_done, 1);
            chk("R5", "eight records", nrec, 8);
            chk("R13", "no error from busy start", got_err, 0);
            chk("R4", "cs high after", int'(cs_n), 1);
            for (int i = 0; i < 8; i++) begin
                chk("R1", "slot kind", r_kind[i], mo[i]);
                chk("R3", "slot pads", r_pads[i], mp[i]);
                chk("R2", "slot bits", r_bits[i], exp_bits(mo[i], mv[i]));
            end
        end

        // Dummy mode rules: R9, R11.
        set_ins(3, 0, 6'h21, 3, 8'hEB); set_ins(3, 1, 6'h0C, 3, 4);
        set_ins(4, 0, 6'h01, 0, 8'h0B); set_ins(4, 1, 6'h2C, 0, 4);
        set_ins(5, 0, 6'h2C, 3, 4);     set_ins(5, 1, 6'h03, 0, 16);
        run(3, 1'b1, 0, 1'b0, 100);
        chk("R9", "sdr dummy in ddr code", got_code, 4);
        chk("R11", "seq index", got_seq, 3);
        chk("R9", "no records", nrec, 0);
        run(4, 1'b1, 0, 1'b0, 100);
        chk("R9", "ddr dummy in sdr code", got_code, 5);
        chk("R11", "seq index", got_seq, 4);
        run(5, 1'b1, 0, 1'b0, 100);
        chk("R9", "pending dummy code", got_code, 5);
        chk("R11", "seq index", got_seq, 5);
        chk("R9", "pending dummy err", got_err, 1);
        set_ins(9, 0, 6'h21, 3, 8'hEB); set_ins(9, 1, 6'h2C, 3, 16); set_ins(9, 2, 6'h29, 3, 64);
        run(9, 1'b1, 0, 1'b0, 100);
        chk("R9", "ddr seq done", got_done, 1);
        chk("R9", "ddr seq records", nrec, 3);
        chk("R2", "ddr flag", r_ddr[1], 1);
        chk("R2", "ddr dummy bits", r_bits[1], 16);

        // Jump pointer: R6, R7, R11.
        set_ins(6, 0, 6'h01, 0, 8'h9F); set_ins(6, 1, 6'h1F, 0, 58);
        set_ins(7, 0, 6'h01, 1, 8'h11); set_ins(7, 1, 6'h00, 0, 0);
        set_ins(7, 2, 6'h09, 2, 4);     set_ins(7, 3, 6'h00, 0, 0);
        run(6, 1'b1, 0, 1'b0, 100);
        chk("R7", "host jump code", got_code, 2);
        chk("R11", "host jump seq", got_seq, 6);
        chk("R7", "host jump cs_n", int'(cs_n), 1);
        run(6, 1'b0, 0, 1'b0, 100);
        chk("R6", "jump done", got_done, 1);
        chk("R6", "jump records", nrec, 1);
        run(0, 1'b0, 0, 1'b0, 100);
        chk("R6", "pointer start done", got_done, 1);
        chk("R6", "pointer start records", nrec, 1);
        chk("R6", "pointer start kind", r_kind[0], 9);
        chk("R6", "pointer start bits", r_bits[0], 4);
        run(7, 1'b1, 0, 1'b0, 100);
        chk("R6", "host ignores pointer kind", r_kind[0], 1);
        chk("R6", "host ignores pointer pads", r_pads[0], 1);

        // Timeout: R10.
        set_ins(8, 0, 6'h01, 0, 5); set_ins(8, 1, 6'h09, 0, 8);
        tmo_limit = 8'd1;
        run(8, 1'b1, 2, 1'b0, 3000);
        chk("R10", "timeout err", got_err, 1);
        chk("R10", "timeout code", got_code, 14);
        chk("R11", "timeout seq", got_seq, 8);
        chk_rng("R10", "timeout cycle", ncyc, 1020, 1030);
        chk("R10", "cs_n after timeout", int'(cs_n), 1);
        tmo_limit = 8'd0;
        run(8, 1'b1, 3, 1'b0, 4000);
        chk("R10", "disabled no err", got_err, 0);
        chk("R10", "disabled done", got_done, 1);
        chk("R10", "disabled records", nrec, 2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule